// File: doc/BRIEF.md
# Write-Protection Command Sequence Detector

This block sits between the write-strobe decoder and the page-load controller of an EEPROM model. Every captured write (address plus data) passes through it. It checks each write against two command sequences: a three-step lock sequence and a six-step unlock sequence. It keeps a protection flag, and for each write it answers one cycle later with two decisions: whether the data may be committed to the array, and whether the write-cycle timer must start even though nothing is stored.

While protection is on, an ordinary write is thrown away but still starts the timer, so reads during that period behave as status polling. Repeating the lock sequence opens a one-page window in which writes are committed. Command writes are never stored. A sequence only changes the flag once the external write-cycle timer reports completion. The page-load gap timeout abandons a partial sequence and closes the window. A soft power-cycle input clears all transient state but leaves the flag alone, which models non-volatile retention. Only the hard reset models first power-up, and it clears the flag.

Top module: `sdp_guard`

## Requirements
- R1: After hard reset `prot_flag`, `wr_done`, `wr_commit` and `timer_req` are all 0.
- R2: Each `wr_evt` pulse gives `wr_done`=1 in the next cycle, and `wr_done` is 0 in every other cycle.
- R3: With protection off, a write outside any command sequence answers `wr_commit`=1 and `timer_req`=0.
- R4: The lock sequence is (0x5555,0xAA), (0x2AAA,0x55), (0x5555,0xA0) in that order. Its writes answer `wr_commit`=0. With protection off, its third write answers `timer_req`=1. `prot_flag` rises in the cycle after the next `wcycle_done` pulse, and not before.
- R5: With protection on, a write outside any command sequence answers `wr_commit`=0 and `timer_req`=1.
- R6: With protection on, the lock sequence answers `wr_commit`=0 and `timer_req`=0 on all three writes. Every following write answers `wr_commit`=1 and `timer_req`=0 until `gap_expired` pulses.
- R7: The unlock sequence is (0x5555,0xAA), (0x2AAA,0x55), (0x5555,0x80), (0x5555,0xAA), (0x2AAA,0x55), (0x5555,0x20). Its writes answer `wr_commit`=0, and only the sixth answers `timer_req`=1. `prot_flag` falls in the cycle after the next `wcycle_done` pulse.
- R8: A write that does not match the expected next step of any sequence returns the detector to idle. That write is answered as an ordinary write, and a sequence must then restart from its first step.
- R9: A `gap_expired` pulse in the middle of a sequence abandons it, so the remaining steps are answered as ordinary writes.
- R10: A `pwr_cycle` pulse never changes `prot_flag`. It abandons partial sequences and cancels a flag change that is still waiting for `wcycle_done`.
- R11: A `wcycle_done` pulse with no completed sequence pending leaves `prot_flag` unchanged.
- R12: `wr_commit` and `timer_req` are never both 1, and neither is 1 without `wr_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hard reset (first power-up), clears the flag |
| pwr_cycle | input | 1 | Soft power-cycle pulse, keeps the flag |
| wr_evt | input | 1 | One-cycle pulse per captured write |
| wr_addr | input | 15 | Captured write address |
| wr_data | input | 8 | Captured write data |
| gap_expired | input | 1 | Page-load gap limit exceeded pulse |
| wcycle_done | input | 1 | Write-cycle timer completion pulse |
| wr_done | output | 1 | Response valid, one cycle after `wr_evt` |
| wr_commit | output | 1 | Write may be stored in the array |
| timer_req | output | 1 | Start write-cycle timer with nothing stored |
| prot_flag | output | 1 | Protection state |

## Verification
Every data value is swept at the first command address, once with protection off and once with it on. Only 0xAA must be taken as a command step: it answers no-commit and no-timer. All other values must follow the ordinary-write rule, which tells the commit path apart from the discard-with-timer path. Both sequences are issued whole, broken by a mismatching step, cut by the gap timeout and cut by a soft power cycle. These runs separate a real restart-to-idle from a matcher that resumes mid-sequence. Timer pulses are placed both with and without a pending change, which shows that the flag moves only on a completed, timed sequence.

// File: rtl/sdp_pkg.sv
package sdp_pkg;
   typedef struct packed {
      logic done;
      logic commit;
      logic timer;
   } sdp_resp_t;

   function automatic int unsigned cnt_width(input int unsigned len);
      return (len < 2) ? 1 : $clog2(len);
   endfunction
endpackage

// File: rtl/sdp_seq_match.sv
module sdp_seq_match #(
   parameter int unsigned AW  = 15,
   parameter int unsigned DW  = 8,
   parameter int unsigned LEN = 3,
   parameter logic [LEN*AW-1:0] ADDRS = '0,
   parameter logic [LEN*DW-1:0] DATAS = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          step,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] data,
   output logic          hit,
   output logic          done
);
   localparam int unsigned CW = sdp_pkg::cnt_width(LEN);

   if (LEN < 2) begin : g_len_chk
      $error("sdp_seq_match: LEN must be at least 2");
   end

   logic [CW-1:0]  pos_q;
   logic [LEN-1:0] step_hit;

   for (genvar i = 0; i < LEN; i++) begin : g_step
      assign step_hit[i] = (pos_q == CW'(i))
                         && (addr == ADDRS[i*AW +: AW])
                         && (data == DATAS[i*DW +: DW]);
   end

   assign hit  = |step_hit;
   assign done = step_hit[LEN-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q <= '0;
      end else if (clr) begin
         pos_q <= '0;
      end else if (step) begin
         pos_q <= (hit && !done) ? pos_q + CW'(1) : '0;
      end
   end
endmodule

// File: rtl/sdp_prot_ctrl.sv
module sdp_prot_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic pwr_cycle,
   input  logic wr_evt,
   input  logic lock_hit,
   input  logic lock_done,
   input  logic unlk_hit,
   input  logic unlk_done,
   input  logic gap_expired,
   input  logic wcycle_done,
   output logic window,
   output logic wr_done,
   output logic wr_commit,
   output logic timer_req,
   output logic prot_flag
);
   import sdp_pkg::*;

   logic      prot_q, window_q, pend_on_q, pend_off_q;
   sdp_resp_t resp_d, resp_q;
   logic      cmd_step;

   assign cmd_step = !window_q && (lock_hit || unlk_hit);

   always_comb begin
      resp_d = '0;
      if (wr_evt) begin
         resp_d.done = 1'b1;
         if (window_q) begin
            resp_d.commit = 1'b1;
         end else if (cmd_step) begin
            resp_d.timer = (lock_done && !prot_q) || unlk_done;
         end else begin
            resp_d.commit = !prot_q;
            resp_d.timer  = prot_q;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prot_q     <= 1'b0;
         window_q   <= 1'b0;
         pend_on_q  <= 1'b0;
         pend_off_q <= 1'b0;
         resp_q     <= '0;
      end else begin
         resp_q <= resp_d;
         if (wcycle_done) begin
            if (pend_on_q) begin
               prot_q <= 1'b1;
            end else if (pend_off_q) begin
               prot_q <= 1'b0;
            end
            pend_on_q  <= 1'b0;
            pend_off_q <= 1'b0;
         end
         if (gap_expired) begin
            window_q <= 1'b0;
         end
         if (wr_evt && !window_q && lock_done) begin
            window_q <= 1'b1;
            if (!prot_q) begin
               pend_on_q  <= 1'b1;
               pend_off_q <= 1'b0;
            end
         end
         if (wr_evt && !window_q && unlk_done) begin
            pend_off_q <= 1'b1;
            pend_on_q  <= 1'b0;
         end
         if (pwr_cycle) begin
            window_q   <= 1'b0;
            pend_on_q  <= 1'b0;
            pend_off_q <= 1'b0;
         end
      end
   end

   assign window    = window_q;
   assign wr_done   = resp_q.done;
   assign wr_commit = resp_q.commit;
   assign timer_req = resp_q.timer;
   assign prot_flag = prot_q;
endmodule

// File: rtl/sdp_guard.sv
module sdp_guard #(
   parameter int unsigned AW       = 15,
   parameter int unsigned DW       = 8,
   parameter int unsigned LOCK_LEN = 3,
   parameter int unsigned UNLK_LEN = 6,
   parameter bit          HAS_UNLK = 1'b1,
   parameter logic [LOCK_LEN*AW-1:0] LOCK_ADDR = {15'h5555, 15'h2AAA, 15'h5555},
   parameter logic [LOCK_LEN*DW-1:0] LOCK_DATA = {8'hA0, 8'h55, 8'hAA},
   parameter logic [UNLK_LEN*AW-1:0] UNLK_ADDR =
      {15'h5555, 15'h2AAA, 15'h5555, 15'h5555, 15'h2AAA, 15'h5555},
   parameter logic [UNLK_LEN*DW-1:0] UNLK_DATA =
      {8'h20, 8'h55, 8'hAA, 8'h80, 8'h55, 8'hAA}
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          pwr_cycle,
   input  logic          wr_evt,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic          gap_expired,
   input  logic          wcycle_done,
   output logic          wr_done,
   output logic          wr_commit,
   output logic          timer_req,
   output logic          prot_flag
);
   localparam int unsigned LAST_LOCK = LOCK_LEN - 1;

   if (AW < 1 || DW < 1) begin : g_width_chk
      $error("sdp_guard: AW and DW must be positive");
   end
   if (HAS_UNLK && UNLK_LEN > LAST_LOCK &&
       UNLK_ADDR[LAST_LOCK*AW +: AW] == LOCK_ADDR[LAST_LOCK*AW +: AW] &&
       UNLK_DATA[LAST_LOCK*DW +: DW] == LOCK_DATA[LAST_LOCK*DW +: DW]) begin : g_seq_chk
      $error("sdp_guard: lock and unlock sequences must differ at the last lock step");
   end

   logic window, step, clr;
   logic lock_hit, lock_done, unlk_hit, unlk_done;

   assign step = wr_evt && !window;
   assign clr  = gap_expired || pwr_cycle || (step && (lock_done || unlk_done));

   sdp_seq_match #(
      .AW(AW), .DW(DW), .LEN(LOCK_LEN), .ADDRS(LOCK_ADDR), .DATAS(LOCK_DATA)
   ) u_lock (
      .clk(clk), .rst_n(rst_n), .clr(clr), .step(step),
      .addr(wr_addr), .data(wr_data), .hit(lock_hit), .done(lock_done)
   );

   if (HAS_UNLK) begin : g_unlk
      sdp_seq_match #(
         .AW(AW), .DW(DW), .LEN(UNLK_LEN), .ADDRS(UNLK_ADDR), .DATAS(UNLK_DATA)
      ) u_unlk (
         .clk(clk), .rst_n(rst_n), .clr(clr), .step(step),
         .addr(wr_addr), .data(wr_data), .hit(unlk_hit), .done(unlk_done)
      );
   end else begin : g_no_unlk
      assign unlk_hit  = 1'b0;
      assign unlk_done = 1'b0;
   end

   sdp_prot_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n), .pwr_cycle(pwr_cycle), .wr_evt(wr_evt),
      .lock_hit(lock_hit), .lock_done(lock_done),
      .unlk_hit(unlk_hit), .unlk_done(unlk_done),
      .gap_expired(gap_expired), .wcycle_done(wcycle_done),
      .window(window), .wr_done(wr_done), .wr_commit(wr_commit),
      .timer_req(timer_req), .prot_flag(prot_flag)
   );
endmodule

// File: rtl/sdp_guard_chk.sv
module sdp_guard_chk (
   input logic clk,
   input logic rst_n,
   input logic pwr_cycle,
   input logic wr_evt,
   input logic wcycle_done,
   input logic wr_done,
   input logic wr_commit,
   input logic timer_req,
   input logic prot_flag
);
   assert_resp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_evt |=> wr_done);
   assert_no_stray_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_evt |=> !wr_done);
   assert_commit_has_resp_R12: assert property (@(posedge clk) disable iff (!rst_n)
      wr_commit |-> wr_done);
   assert_timer_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
      timer_req |-> (wr_done && !wr_commit));
   assert_flag_on_timer_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(prot_flag) |-> $past(wcycle_done));
   assert_flag_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_cycle && prot_flag && !wcycle_done) |=> prot_flag);
endmodule

bind sdp_guard sdp_guard_chk u_sdp_guard_chk (
   .clk(clk), .rst_n(rst_n), .pwr_cycle(pwr_cycle), .wr_evt(wr_evt),
   .wcycle_done(wcycle_done), .wr_done(wr_done), .wr_commit(wr_commit),
   .timer_req(timer_req), .prot_flag(prot_flag)
);

// File: tb/sdp_guard_tb.sv
module sdp_guard_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pwr_cycle = 1'b0;
   logic        wr_evt = 1'b0;
   logic [14:0] wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic        gap_expired = 1'b0;
   logic        wcycle_done = 1'b0;
   logic        wr_done, wr_commit, timer_req, prot_flag;
   int          checks = 0;
   int          errors = 0;
   bit          finished = 1'b0;

   always #10 clk = ~clk;

   sdp_guard u_dut (
      .clk(clk), .rst_n(rst_n), .pwr_cycle(pwr_cycle), .wr_evt(wr_evt),
      .wr_addr(wr_addr), .wr_data(wr_data), .gap_expired(gap_expired),
      .wcycle_done(wcycle_done), .wr_done(wr_done), .wr_commit(wr_commit),
      .timer_req(timer_req), .prot_flag(prot_flag)
   );

   task automatic chk(input logic act, input logic exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%b expected=%b", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [14:0] a, input logic [7:0] d,
                     input logic ec, input logic et, input string tag);
      wr_evt = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_evt = 1'b0;
      chk(wr_done, 1'b1, {tag, " done"});
      chk(wr_commit, ec, {tag, " commit"});
      chk(timer_req, et, {tag, " timer"});
   endtask

   task automatic pulse(input int which);
      case (which)
         0: gap_expired = 1'b1;
         1: wcycle_done = 1'b1;
         default: pwr_cycle = 1'b1;
      endcase
      @(negedge clk);
      gap_expired = 1'b0; wcycle_done = 1'b0; pwr_cycle = 1'b0;
   endtask

   task automatic lock_seq(input logic et, input string tag);
      wr(15'h5555, 8'hAA, 1'b0, 1'b0, tag);
      wr(15'h2AAA, 8'h55, 1'b0, 1'b0, tag);
      wr(15'h5555, 8'hA0, 1'b0, et, tag);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(prot_flag, 1'b0, "R1 reset flag");
      chk(wr_done, 1'b0, "R1 reset done");
      chk(wr_commit, 1'b0, "R1 reset commit");
      chk(timer_req, 1'b0, "R1 reset timer");
      rst_n = 1'b1;
      @(negedge clk);
      chk(wr_done, 1'b0, "R2 idle no response");

      // R3/R8 sweep, protection off: only 0xAA at 0x5555 is a command step
      for (int d = 0; d < 256; d++)
         wr(15'h5555, 8'(d), (d != 8'hAA), 1'b0, "R3 sweep off");
      for (int d = 0; d < 256; d += 5)
         wr(15'h2AAA, 8'(d), 1'b1, 1'b0, "R3 sweep off alt addr");
      @(negedge clk);
      chk(wr_done, 1'b0, "R2 single response");

      // R4 lock sequence
      lock_seq(1'b1, "R4 lock");
      pulse(0);
      chk(prot_flag, 1'b0, "R4 flag waits for timer");
      pulse(1);
      chk(prot_flag, 1'b1, "R4 flag set after timer");
      pulse(1);
      chk(prot_flag, 1'b1, "R11 idle timer pulse");

      // R5 sweep, protection on
      for (int d = 0; d < 256; d++)
         wr(15'h5555, 8'(d), 1'b0, (d != 8'hAA), "R5 sweep on");

      // R6 unlock-by-prefix window
      lock_seq(1'b0, "R6 prefix");
      wr(15'h0123, 8'h11, 1'b1, 1'b0, "R6 window write a");
      wr(15'h0124, 8'h22, 1'b1, 1'b0, "R6 window write b");
      pulse(0);
      wr(15'h0125, 8'h33, 1'b0, 1'b1, "R6 after window");
      chk(prot_flag, 1'b1, "R6 flag unchanged");

      // R8 mismatch mid-sequence
      wr(15'h5555, 8'hAA, 1'b0, 1'b0, "R8 step1");
      wr(15'h2AAA, 8'h56, 1'b0, 1'b1, "R8 mismatch ordinary");
      wr(15'h5555, 8'hA0, 1'b0, 1'b1, "R8 no resume");
      wr(15'h1000, 8'h00, 1'b0, 1'b1, "R8 no window");

      // R9 gap abandons
      wr(15'h5555, 8'hAA, 1'b0, 1'b0, "R9 step1");
      wr(15'h2AAA, 8'h55, 1'b0, 1'b0, "R9 step2");
      pulse(0);
      wr(15'h5555, 8'hA0, 1'b0, 1'b1, "R9 abandoned");

      // R10 soft power cycle abandons, keeps flag
      wr(15'h5555, 8'hAA, 1'b0, 1'b0, "R10 step1");
      wr(15'h2AAA, 8'h55, 1'b0, 1'b0, "R10 step2");
      pulse(2);
      chk(prot_flag, 1'b1, "R10 flag kept");
      wr(15'h5555, 8'hA0, 1'b0, 1'b1, "R10 abandoned");

      // R7 unlock sequence
      wr(15'h5555, 8'hAA, 1'b0, 1'b0, "R7 s1");
      wr(15'h2AAA, 8'h55, 1'b0, 1'b0, "R7 s2");
      wr(15'h5555, 8'h80, 1'b0, 1'b0, "R7 s3");
      wr(15'h5555, 8'hAA, 1'b0, 1'b0, "R7 s4");
      wr(15'h2AAA, 8'h55, 1'b0, 1'b0, "R7 s5");
      wr(15'h5555, 8'h20, 1'b0, 1'b1, "R7 s6");
      chk(prot_flag, 1'b1, "R7 flag waits for timer");
      pulse(1);
      chk(prot_flag, 1'b0, "R7 flag cleared");
      wr(15'h0200, 8'h5A, 1'b1, 1'b0, "R3 ordinary after unlock");

      // R10 pending change cancelled by soft power cycle
      lock_seq(1'b1, "R10 lock");
      pulse(0);
      pulse(2);
      pulse(1);
      chk(prot_flag, 1'b0, "R10 pending cancelled");

      // R10 flag survives soft power cycle, cleared by hard reset
      lock_seq(1'b1, "R4 relock");
      pulse(0);
      pulse(1);
      chk(prot_flag, 1'b1, "R4 relock set");
      pulse(2);
      chk(prot_flag, 1'b1, "R10 flag survives power cycle");
      rst_n = 1'b0;
      @(negedge clk);
      chk(prot_flag, 1'b0, "R1 hard reset clears flag");
      rst_n = 1'b1;
      @(negedge clk);

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule